// File: doc/BRIEF.md
# System Control Space Address Decoder

This block decodes the 1 MiB system control address space of a microcontroller and steers each request to one of four register targets: the system control and interrupt register page, a non-secure tick timer, a secure tick timer, and an optional reliability register page. The tick timer window sits inside the system control page, so overlapping windows are settled by a fixed priority. Each request carries a secure attribute and an unprivileged attribute. The timer window goes to the timer bank that matches the secure attribute.

An optional non-secure alias page lets secure software reach the non-secure view of the control registers. A secure access to the alias reaches the main target with the secure attribute cleared. A non-secure access to the alias is blocked. Space that no target claims behaves as empty memory for privileged callers and faults for unprivileged ones. The target is chosen in the request cycle. The chosen target's read data and error flag are registered and come back one cycle later.

Top module: `ppb_decoder`

## Requirements
- R1: After reset, rsp_valid, rsp_err and rsp_rdata are all zero.
- R2: In the request cycle, tgt_sel has at most one bit set, and none when req_valid is low. rsp_valid is high exactly in the cycle after a cycle with req_valid high.
- R3: Addresses 0xE000E000..0xE000EFFF outside the timer window select target 0 (tgt_sel bit 0). tgt_secure equals req_secure and tgt_offs equals req_addr[11:0].
- R4: Addresses 0xE000E010..0xE000E0EF take priority over target 0. A secure access selects target 2 (secure timer, bit 2) and a non-secure access selects target 1 (non-secure timer, bit 1).
- R5: An address inside 0xE0000000..0xE00FFFFF that no target claims selects no target and returns rsp_rdata zero. A privileged access gets rsp_err low and an unprivileged access (req_user high) gets rsp_err high.
- R6: On unclaimed addresses, a req_size of 1 to 8 bytes is accepted. A req_size of 0 or above 8 gives rsp_err high.
- R7: A secure access to the alias page 0xE002E000..0xE002EFFF is forwarded with tgt_secure low. Alias offsets 0x010..0x0EF go to target 1 and all other alias offsets go to target 0. tgt_offs equals req_addr[11:0].
- R8: A non-secure access to the alias page selects no target and returns zero data. rsp_err equals req_user.
- R9: Addresses 0xE0005000..0xE0005FFF select target 3 (reliability block) ahead of the default region.
- R10: An address outside 0xE0000000..0xE00FFFFF selects no target and gives rsp_err high.
- R11: When a target is selected, the next cycle's rsp_rdata and rsp_err are that target's tgt_rdata slice and tgt_err bit, as they were in the request cycle.
- R12: With HAS_SEC_TICK, HAS_ALIAS and HAS_REL cleared, the disabled windows fall through to the next lower priority. Secure timer accesses go to target 0. Alias and reliability addresses get the default response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| req_size | input | 4 | Access size in bytes |
| req_secure | input | 1 | Secure attribute |
| req_user | input | 1 | Unprivileged attribute |
| tgt_sel | output | 4 | One-hot target select: 0 control, 1 timer NS, 2 timer S, 3 reliability |
| tgt_offs | output | 12 | Offset within the 4 KiB page |
| tgt_write | output | 1 | Forwarded write flag |
| tgt_wdata | output | DW | Forwarded write data |
| tgt_size | output | 4 | Forwarded size |
| tgt_secure | output | 1 | Forwarded secure attribute (cleared through the alias) |
| tgt_user | output | 1 | Forwarded unprivileged attribute |
| tgt_rdata | input | 4*DW | Read data of each target, target 0 in the low slice |
| tgt_err | input | 4 | Error flag of each target |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | DW | Response read data |
| rsp_err | output | 1 | Response bus error |

## Verification
The bench targets the window edges where the timer window begins and ends inside the control page. A decoder with the priority inverted, or with an off-by-one limit, would send the first or last timer word to the control registers. It sweeps secure and non-secure callers across the alias page. A design that forgot to clear the secure attribute would hand the secure register bank to the forwarded access, and one that let non-secure callers through would leak registers. Unclaimed space is driven with both privilege levels and with out-of-range sizes. A fault-free default region or a stray data value would show up there. A second instance with every option disabled shows whether disabled windows fall through instead of swallowing accesses.

// File: rtl/ppb_pkg.sv
// Package: shared constants and target encoding for the system control space decoder.
// Assumes four targets and six address windows, indexed as below.
package ppb_pkg;
    localparam int NUM_TGT = 4;
    localparam int NUM_WIN = 6;

    // Target slot numbers; tgt_sel bit positions follow these.
    typedef enum logic [1:0] {
        TGT_CTRL    = 2'd0,
        TGT_TICK_NS = 2'd1,
        TGT_TICK_S  = 2'd2,
        TGT_RELY    = 2'd3
    } tgt_e;

    // Window slot numbers inside the route module.
    localparam int W_SPACE = 0;
    localparam int W_CTRL  = 1;
    localparam int W_TICK  = 2;
    localparam int W_ACTRL = 3;
    localparam int W_ATICK = 4;
    localparam int W_RELY  = 5;
endpackage

// File: rtl/ppb_window.sv
// Module: single address window comparator.
// Assumes the window does not wrap the top of the address space; EN=0 ties hit low.
module ppb_window #(
    parameter int              AW   = 32,
    parameter logic [AW-1:0]   BASE = '0,
    parameter logic [AW-1:0]   SIZE = 'h1000,
    parameter bit              EN   = 1'b1
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    // Window test: offset from base below size, using modular subtraction.
    always_comb hit = EN && ((addr - BASE) < SIZE);
endmodule

// File: rtl/ppb_route.sv
// Module: priority router. Picks one target per request, rewrites the secure
// attribute for alias accesses and computes the default-region error.
// Assumes the timer window lies inside the control page, and the alias timer inside the alias page.
module ppb_route
    import ppb_pkg::*;
#(
    parameter int            AW           = 32,
    parameter logic [AW-1:0] SPACE_BASE   = 32'hE000_0000,
    parameter logic [AW-1:0] SPACE_SIZE   = 32'h0010_0000,
    parameter logic [AW-1:0] CTRL_BASE    = 32'hE000_E000,
    parameter logic [AW-1:0] PAGE_SIZE    = 32'h0000_1000,
    parameter logic [AW-1:0] TICK_BASE    = 32'hE000_E010,
    parameter logic [AW-1:0] TICK_SIZE    = 32'h0000_00E0,
    parameter logic [AW-1:0] ALIAS_BASE   = 32'hE002_E000,
    parameter logic [AW-1:0] RELY_BASE    = 32'hE000_5000,
    parameter int            MAX_SIZE     = 8,
    parameter bit            HAS_SEC_TICK = 1'b1,
    parameter bit            HAS_ALIAS    = 1'b1,
    parameter bit            HAS_REL      = 1'b1
) (
    input  logic               req_valid,
    input  logic [AW-1:0]      req_addr,
    input  logic [3:0]         req_size,
    input  logic               req_secure,
    input  logic               req_user,
    output logic [NUM_TGT-1:0] sel,
    output logic               fwd_secure,
    output logic               dflt_err
);
    localparam logic [AW-1:0] ATICK_BASE = ALIAS_BASE + (TICK_BASE - CTRL_BASE);
    localparam logic [AW-1:0] W_BASE [NUM_WIN] =
        '{SPACE_BASE, CTRL_BASE, TICK_BASE, ALIAS_BASE, ATICK_BASE, RELY_BASE};
    localparam logic [AW-1:0] W_SIZE [NUM_WIN] =
        '{SPACE_SIZE, PAGE_SIZE, TICK_SIZE, PAGE_SIZE, TICK_SIZE, PAGE_SIZE};
    localparam bit W_EN [NUM_WIN] =
        '{1'b1, 1'b1, 1'b1, HAS_ALIAS, HAS_ALIAS, HAS_REL};

    logic [NUM_WIN-1:0] hit;
    logic               size_bad;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        ppb_window #(
            .AW  (AW),
            .BASE(W_BASE[w]),
            .SIZE(W_SIZE[w]),
            .EN  (W_EN[w])
        ) u_win (
            .addr(req_addr),
            .hit (hit[w])
        );
    end

    // Size legality for the default region.
    always_comb size_bad = (req_size == 4'd0) || (int'(req_size) > MAX_SIZE);

    // Priority decision: space check, alias page, timer, control, reliability, default.
    always_comb begin
        sel        = '0;
        fwd_secure = req_secure;
        dflt_err   = 1'b0;
        if (req_valid) begin
            if (!hit[W_SPACE]) begin
                dflt_err = 1'b1;
            end else if (hit[W_ACTRL]) begin
                if (req_secure) begin
                    fwd_secure = 1'b0;
                    if (hit[W_ATICK]) sel[TGT_TICK_NS] = 1'b1;
                    else              sel[TGT_CTRL]    = 1'b1;
                end else begin
                    dflt_err = req_user;
                end
            end else if (hit[W_TICK] && !req_secure) begin
                sel[TGT_TICK_NS] = 1'b1;
            end else if (hit[W_TICK] && HAS_SEC_TICK) begin
                sel[TGT_TICK_S] = 1'b1;
            end else if (hit[W_CTRL]) begin
                sel[TGT_CTRL] = 1'b1;
            end else if (hit[W_RELY]) begin
                sel[TGT_RELY] = 1'b1;
            end else begin
                dflt_err = req_user || size_bad;
            end
        end
    end
endmodule

// File: rtl/ppb_resp_mux.sv
// Module: response multiplexer and response register.
// Assumes sel is one-hot or zero; with no selection the default response is used.
module ppb_resp_mux
    import ppb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [NUM_TGT-1:0]    sel,
    input  logic                  dflt_err,
    input  logic [NUM_TGT*DW-1:0] tgt_rdata,
    input  logic [NUM_TGT-1:0]    tgt_err,
    output logic                  rsp_valid,
    output logic [DW-1:0]         rsp_rdata,
    output logic                  rsp_err
);
    logic [DW-1:0] slice_and [NUM_TGT];
    logic [DW-1:0] mux_rdata;
    logic          mux_err;

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_gate
        // Gate each target's data by its select bit.
        always_comb slice_and[t] = tgt_rdata[t*DW +: DW] & {DW{sel[t]}};
    end

    // OR-combine the gated slices; default response when nothing is selected.
    always_comb begin
        mux_rdata = '0;
        for (int t = 0; t < NUM_TGT; t++) mux_rdata |= slice_and[t];
        mux_err = (|sel) ? |(tgt_err & sel) : dflt_err;
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= req_valid ? mux_rdata : '0;
            rsp_err   <= req_valid && mux_err;
        end
    end
endmodule

// File: rtl/ppb_decoder.sv
// Module: top of the system control space decoder. Routes a request to one of
// four register targets in the same cycle and returns the registered response.
// Assumes targets answer combinationally from tgt_* in the request cycle.
module ppb_decoder
    import ppb_pkg::*;
#(
    parameter int            AW           = 32,
    parameter int            DW           = 32,
    parameter logic [AW-1:0] SPACE_BASE   = 32'hE000_0000,
    parameter logic [AW-1:0] SPACE_SIZE   = 32'h0010_0000,
    parameter logic [AW-1:0] CTRL_BASE    = 32'hE000_E000,
    parameter logic [AW-1:0] PAGE_SIZE    = 32'h0000_1000,
    parameter logic [AW-1:0] TICK_BASE    = 32'hE000_E010,
    parameter logic [AW-1:0] TICK_SIZE    = 32'h0000_00E0,
    parameter logic [AW-1:0] ALIAS_BASE   = 32'hE002_E000,
    parameter logic [AW-1:0] RELY_BASE    = 32'hE000_5000,
    parameter int            MAX_SIZE     = 8,
    parameter bit            HAS_SEC_TICK = 1'b1,
    parameter bit            HAS_ALIAS    = 1'b1,
    parameter bit            HAS_REL      = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [AW-1:0]         req_addr,
    input  logic                  req_write,
    input  logic [DW-1:0]         req_wdata,
    input  logic [3:0]            req_size,
    input  logic                  req_secure,
    input  logic                  req_user,
    output logic [NUM_TGT-1:0]    tgt_sel,
    output logic [11:0]           tgt_offs,
    output logic                  tgt_write,
    output logic [DW-1:0]         tgt_wdata,
    output logic [3:0]            tgt_size,
    output logic                  tgt_secure,
    output logic                  tgt_user,
    input  logic [NUM_TGT*DW-1:0] tgt_rdata,
    input  logic [NUM_TGT-1:0]    tgt_err,
    output logic                  rsp_valid,
    output logic [DW-1:0]         rsp_rdata,
    output logic                  rsp_err
);
    logic dflt_err;

    ppb_route #(
        .AW(AW), .SPACE_BASE(SPACE_BASE), .SPACE_SIZE(SPACE_SIZE),
        .CTRL_BASE(CTRL_BASE), .PAGE_SIZE(PAGE_SIZE), .TICK_BASE(TICK_BASE),
        .TICK_SIZE(TICK_SIZE), .ALIAS_BASE(ALIAS_BASE), .RELY_BASE(RELY_BASE),
        .MAX_SIZE(MAX_SIZE), .HAS_SEC_TICK(HAS_SEC_TICK),
        .HAS_ALIAS(HAS_ALIAS), .HAS_REL(HAS_REL)
    ) u_route (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_secure(req_secure),
        .req_user  (req_user),
        .sel       (tgt_sel),
        .fwd_secure(tgt_secure),
        .dflt_err  (dflt_err)
    );

    ppb_resp_mux #(.DW(DW)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .sel      (tgt_sel),
        .dflt_err (dflt_err),
        .tgt_rdata(tgt_rdata),
        .tgt_err  (tgt_err),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .rsp_err  (rsp_err)
    );

    // Pass-through of the request fields every target shares.
    always_comb begin
        tgt_offs  = req_addr[11:0];
        tgt_write = req_write;
        tgt_wdata = req_wdata;
        tgt_size  = req_size;
        tgt_user  = req_user;
    end
endmodule

// File: rtl/ppb_decoder_sva.sv
// Module: assertion checker for ppb_decoder, attached by bind below.
// Assumes the default address map of the decoder.
module ppb_decoder_sva #(
    parameter int            AW         = 32,
    parameter int            DW         = 32,
    parameter logic [AW-1:0] SPACE_BASE = 32'hE000_0000,
    parameter logic [AW-1:0] SPACE_SIZE = 32'h0010_0000,
    parameter logic [AW-1:0] ALIAS_BASE = 32'hE002_E000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic          req_secure,
    input logic          req_user,
    input logic [3:0]    tgt_sel,
    input logic          tgt_secure,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_rdata,
    input logic          rsp_err
);
    logic in_alias;
    logic in_space;
    // Address classification used by the properties.
    always_comb begin
        in_alias = req_addr[AW-1:12] == ALIAS_BASE[AW-1:12];
        in_space = (req_addr - SPACE_BASE) < SPACE_SIZE;
    end

    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_sel));
    a_r2_idle_nosel: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> tgt_sel == 4'd0);
    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r4_secure_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sel[2] |-> req_secure && !in_alias);
    a_r7_alias_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_alias && tgt_sel != 4'd0) |-> !tgt_secure);
    a_r8_alias_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_alias && !req_secure) |-> tgt_sel == 4'd0);
    a_r5_user_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && tgt_sel == 4'd0 && req_user) |=> rsp_err);
    a_r5_raz: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && tgt_sel == 4'd0) |=> rsp_rdata == '0);
    a_r10_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_space) |=> rsp_err);
endmodule

bind ppb_decoder ppb_decoder_sva #(
    .AW(AW), .DW(DW), .SPACE_BASE(SPACE_BASE), .SPACE_SIZE(SPACE_SIZE),
    .ALIAS_BASE(ALIAS_BASE)
) u_sva (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_secure(req_secure), .req_user(req_user), .tgt_sel(tgt_sel),
    .tgt_secure(tgt_secure), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err)
);

// File: tb/ppb_decoder_tb.sv
// Bench: full-option instance u_dut plus an all-options-off instance, stub targets,
// seeded random and directed requests checked against a bench model.
module ppb_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_size = 4'd4;
    logic        req_secure = 1'b0;
    logic        req_user = 1'b0;

    logic [3:0]   sel_a, sel_b, err_a, err_b;
    logic [11:0]  offs_a, offs_b;
    logic         sec_a, sec_b, wr_a, wr_b, us_a, us_b;
    logic [31:0]  wd_a, wd_b;
    logic [3:0]   sz_a, sz_b;
    logic [127:0] rd_a, rd_b;
    logic         rv_a, rv_b, re_a, re_b;
    logic [31:0]  rdat_a, rdat_b;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [31:0] stub_rd(int t, logic [11:0] o);
        return {4'hC, 4'(t), 12'h000, o};
    endfunction
    function automatic logic stub_er(logic [11:0] o);
        return o == 12'hFFC;
    endfunction

    // Stub targets: data encodes target number and offset.
    always_comb begin
        for (int t = 0; t < 4; t++) begin
            rd_a[t*32 +: 32] = stub_rd(t, offs_a);
            rd_b[t*32 +: 32] = stub_rd(t, offs_b);
            err_a[t] = stub_er(offs_a);
            err_b[t] = stub_er(offs_b);
        end
    end

    ppb_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_size(req_size),
        .req_secure(req_secure), .req_user(req_user), .tgt_sel(sel_a),
        .tgt_offs(offs_a), .tgt_write(wr_a), .tgt_wdata(wd_a), .tgt_size(sz_a),
        .tgt_secure(sec_a), .tgt_user(us_a), .tgt_rdata(rd_a), .tgt_err(err_a),
        .rsp_valid(rv_a), .rsp_rdata(rdat_a), .rsp_err(re_a));

    ppb_decoder #(.HAS_SEC_TICK(1'b0), .HAS_ALIAS(1'b0), .HAS_REL(1'b0)) u_dut_min (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_size(req_size),
        .req_secure(req_secure), .req_user(req_user), .tgt_sel(sel_b),
        .tgt_offs(offs_b), .tgt_write(wr_b), .tgt_wdata(wd_b), .tgt_size(sz_b),
        .tgt_secure(sec_b), .tgt_user(us_b), .tgt_rdata(rd_b), .tgt_err(err_b),
        .rsp_valid(rv_b), .rsp_rdata(rdat_b), .rsp_err(re_b));

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bench model of the address map from the requirements.
    function automatic void model(input logic [31:0] a, input logic sec, input logic usr,
                                  input logic [3:0] sz, input bit full,
                                  output int tgt, output logic fsec, output logic derr,
                                  output string tag);
        logic [19:0] o = a[19:0];
        tgt = -1; fsec = sec; derr = 1'b0;
        if (a[31:20] != 12'hE00) begin
            derr = 1'b1; tag = "R10";
        end else if (full && o >= 20'h2E000 && o <= 20'h2EFFF) begin
            if (sec) begin
                fsec = 1'b0; tag = "R7";
                tgt = (o[11:0] >= 12'h010 && o[11:0] <= 12'h0EF) ? 1 : 0;
            end else begin
                derr = usr; tag = "R8";
            end
        end else if (o >= 20'hE010 && o <= 20'hE0EF) begin
            tgt = !sec ? 1 : (full ? 2 : 0); tag = full ? "R4" : "R12";
        end else if (o >= 20'hE000 && o <= 20'hEFFF) begin
            tgt = 0; tag = "R3";
        end else if (full && o >= 20'h5000 && o <= 20'h5FFF) begin
            tgt = 3; tag = "R9";
        end else begin
            derr = usr || sz == 0 || sz > 8;
            tag = (sz == 0 || sz > 8) ? "R6" : "R5";
        end
        if (!full && tag != "R10") tag = {tag, "/R12"};
    endfunction

    task automatic check_route(bit full, logic [31:0] a, logic s, logic u, logic [3:0] z,
                               output logic [31:0] erd, output logic eer);
        int t; logic fs, de; string tag;
        logic [3:0] esel, asel; logic asec; logic [11:0] aoff;
        model(a, s, u, z, full, t, fs, de, tag);
        esel = (t >= 0) ? 4'(1 << t) : 4'd0;
        asel = full ? sel_a : sel_b;
        asec = full ? sec_a : sec_b;
        aoff = full ? offs_a : offs_b;
        check(asel == esel, {tag, " select"}, asel, esel);
        if (t >= 0) begin
            check(asec == fs, {tag, " secure"}, asec, fs);
            check(aoff == a[11:0], {tag, " offset"}, aoff, a[11:0]);
            erd = stub_rd(t, a[11:0]);
            eer = stub_er(a[11:0]);
        end else begin
            erd = '0;
            eer = de;
        end
    endtask

    // One request: drive at a falling edge, check routing, then the response (R2, R11).
    task automatic xact(logic [31:0] a, logic s, logic u, logic [3:0] z);
        logic [31:0] erd_a, erd_b; logic eer_a, eer_b;
        req_valid = 1'b1; req_addr = a; req_secure = s; req_user = u; req_size = z;
        req_write = $urandom_range(0, 1) == 1; req_wdata = $urandom;
        #1;
        check_route(1'b1, a, s, u, z, erd_a, eer_a);
        check_route(1'b0, a, s, u, z, erd_b, eer_b);
        @(negedge clk);
        check(rv_a && rv_b, "R2 rsp_valid", {rv_a, rv_b}, 2'b11);
        check(rdat_a == erd_a && re_a == eer_a, "R11 response",
              {re_a, rdat_a}, {eer_a, erd_a});
        check(rdat_b == erd_b && re_b == eer_b, "R11/R12 response",
              {re_b, rdat_b}, {eer_b, erd_b});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] bases [8];
        void'($urandom(32'd20240611));
        bases = '{32'hE000_E000, 32'hE000_E010, 32'hE002_E000, 32'hE002_E010,
                  32'hE000_5000, 32'hE000_0000, 32'hE008_0000, 32'h0000_0000};
        repeat (3) @(negedge clk);
        check(!rv_a && !re_a && rdat_a == 0, "R1 reset state", {rv_a, re_a, rdat_a}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sel_a == 0 && !rv_a, "R2 idle", {sel_a, rv_a}, 0);
        // Directed edges.
        xact(32'hE000_E00C, 1'b1, 1'b0, 4'd4);
        xact(32'hE000_E010, 1'b1, 1'b0, 4'd4);
        xact(32'hE000_E010, 1'b0, 1'b0, 4'd4);
        xact(32'hE000_E0EC, 1'b1, 1'b1, 4'd4);
        xact(32'hE000_E0F0, 1'b0, 1'b0, 4'd4);
        xact(32'hE000_EFFC, 1'b0, 1'b0, 4'd4);
        xact(32'hE000_DFFC, 1'b0, 1'b0, 4'd4);
        xact(32'hE000_DFFC, 1'b0, 1'b1, 4'd4);
        xact(32'hE000_F000, 1'b1, 1'b0, 4'd8);
        xact(32'hE000_F000, 1'b1, 1'b0, 4'd0);
        xact(32'hE000_F000, 1'b0, 1'b0, 4'd9);
        xact(32'hE000_1000, 1'b0, 1'b0, 4'd1);
        xact(32'hE002_E000, 1'b1, 1'b0, 4'd4);
        xact(32'hE002_E010, 1'b1, 1'b1, 4'd4);
        xact(32'hE002_E010, 1'b0, 1'b0, 4'd4);
        xact(32'hE002_E010, 1'b0, 1'b1, 4'd4);
        xact(32'hE000_5000, 1'b0, 1'b0, 4'd4);
        xact(32'hE000_5FFC, 1'b1, 1'b1, 4'd4);
        xact(32'hE010_0000, 1'b1, 1'b0, 4'd4);
        xact(32'hDFFF_FFFC, 1'b0, 1'b0, 4'd4);
        // Random mix around the windows.
        for (int i = 0; i < 400; i++) begin
            int k = $urandom_range(0, 7);
            logic [31:0] a;
            if (k == 7) a = $urandom;
            else if (k == 1 || k == 3) a = bases[k] + ($urandom & 32'hFC) - 32'h10;
            else a = bases[k] + ($urandom & 32'hFFC);
            xact(a, 1'($urandom), 1'($urandom), 4'($urandom_range(0, 9)));
        end
        req_valid = 1'b0;
        #1;
        check(sel_a == 0 && sel_b == 0, "R2 no select when idle", {sel_a, sel_b}, 0);
        @(negedge clk);
        check(!rv_a && !rv_b, "R2 no response when idle", {rv_a, rv_b}, 0);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule